// File: doc/BRIEF.md
# Serial SRAM Sample Store Engine

This block sits between a sample-rate delay controller and a bank of byte-addressed serial SRAM devices. The controller hands it one request at a time: a write carries an 18-bit sample address and a 12-bit sample, and a read carries only an address. The engine maps the address to a device and a byte offset and builds the serial frame. It lowers that device's chip-select, shifts the frame out in SPI mode 0, captures any returned bytes, and reports completion with a one-cycle done pulse.

Two storage formats are selectable per request. Slot format stores each sample in its own 16-bit word, so every write is a plain store with no read-modify-write. Packed format stores two samples in three bytes. An even-addressed write only parks the sample inside the engine. The following odd-addressed write sends both samples in one frame. An even-addressed read fetches the pair, returns the even sample and keeps the odd one. The following odd-addressed read returns the kept sample with no bus traffic. A controller that alternates these on successive sample ticks therefore needs one frame per tick. The SCK half-period, in clock cycles, is a parameter.

Top module: `ssr_sample_engine`

## Requirements
- R1: Every frame is sent most significant bit first. It is a command byte (0x02 for write, 0x03 for read), then a 24-bit byte address, then the data bytes. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on SCK rising edges.
- R2: During a frame exactly one chip-select is low and it stays low for the whole frame. When no frame is in progress, all chip-selects are high and SCK is low.
- R3: A slot-format write sends a 48-bit frame whose two data bytes are {4'b0000, d[11:8]} followed by d[7:0].
- R4: In slot format, the device number is address bits [17:16]. The byte address is address bits [15:0] shifted left by one.
- R5: A slot-format read sends a 48-bit frame and returns the low 12 bits of the 16-bit word. The upper 4 bits of the word have no effect on the result.
- R6: A packed-format write to an even address sends no frame. It holds the sample, and done pulses in the cycle after acceptance.
- R7: A packed-format write to an odd address sends a 56-bit frame carrying the held even sample E and the current sample O as the bytes E[11:4], {E[3:0], O[11:8]}, O[7:0].
- R8: In packed format, the pair index p is the address shifted right by one, and G = DEV_BYTES/3 (43690 by default). The device is p/G and the byte address is 3*(p mod G).
- R9: A packed-format read from an even address sends a 56-bit frame. It returns the even sample (the first 12 data bits) and holds the odd sample.
- R10: A packed-format read from an odd address sends no frame. It returns the held odd sample, and done pulses in the cycle after acceptance.
- R11: A request is accepted only when busy is low; a request presented while busy is ignored. After a frame request is accepted, busy is high for 2*N*SCK_HALF cycles (N is the frame's bit count). Done then pulses for one cycle, in the first cycle with the chip-select released, and rd_data is valid in that cycle.
- R12: While reset is held, all chip-selects are high, SCK is low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Sample address |
| req_data | input | 12 | Sample to write |
| pack_mode | input | 1 | 1 = packed format, 0 = slot format |
| busy | output | 1 | Frame in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 12 | Read result, valid with done |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to devices |
| spi_miso | input | 1 | Serial data from devices |
| spi_cs_n | output | NUM_DEV | Active-low device selects |

## Verification
The bench aims at the address-mapping edges. In slot format it uses the top address. In packed format it uses the pair indices just below and at one device's group count, and the last pair index. A divider off by one there would select the wrong chip-select or emit a byte offset past a device boundary. It checks the packed byte layout and the handover of the held even and odd samples: a swapped nibble, or a hold register updated on the wrong request, returns the wrong sample on the frame-less reads. It preloads a slot word with a nonzero upper nibble, which catches a design that leaks those bits into rd_data. It also keeps a request asserted through a busy frame; an engine that samples it would start a second frame or corrupt another address.

// File: rtl/ssr_pkg.sv
// Package: shared constants and byte-layout helpers for the serial SRAM
// sample engine. Assumes 12-bit samples and a 3-byte device address field.
package ssr_pkg;
    localparam int SMP_W   = 12;
    localparam int FRAME_W = 56;
    localparam int BADDR_W = 24;
    localparam int RX_W    = 24;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [5:0] BITS_SLOT = 6'd48;
    localparam logic [5:0] BITS_PACK = 6'd56;

    // Pack an even/odd sample pair into three bytes, even sample first.
    function automatic logic [23:0] pack_pair(input logic [SMP_W-1:0] ev,
                                              input logic [SMP_W-1:0] od);
        return {ev, od};
    endfunction

    // Right-justify one sample in a 16-bit slot with a zero upper nibble.
    function automatic logic [15:0] slot_word(input logic [SMP_W-1:0] s);
        return {4'b0000, s};
    endfunction
endpackage

// File: rtl/ssr_addr_map.sv
// Address mapper: turns a sample address into a device index and a byte
// address for either storage format. Assumes NUM_DEV is a power of two for
// slot format and that NUM_DEV*(DEV_BYTES/3) covers nearly all pair indices.
module ssr_addr_map #(
    parameter int ADDR_W    = 18,
    parameter int NUM_DEV   = 4,
    parameter int DEV_BYTES = 131072
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       packed_fmt,
    output logic [$clog2(NUM_DEV)-1:0] dev_idx,
    output logic [23:0]                byte_addr
);
    localparam int DEV_W  = $clog2(NUM_DEV);
    localparam int PAIR_W = ADDR_W - 1;
    localparam int GROUPS = DEV_BYTES / 3;
    localparam int SLOT_W = ADDR_W - DEV_W + 1;

    logic [PAIR_W-1:0]  pair;
    logic [NUM_DEV-1:0] at_or_above;
    logic [DEV_W-1:0]   pk_dev;
    logic [PAIR_W-1:0]  pk_base;
    logic [23:0]        pk_off;
    logic [DEV_W-1:0]   sl_dev;
    logic [23:0]        sl_byte;

    assign pair = addr[ADDR_W-1:1];

    // One threshold compare per device boundary.
    assign at_or_above[0] = 1'b1;
    for (genvar k = 1; k < NUM_DEV; k++) begin : g_bound
        assign at_or_above[k] = (pair >= PAIR_W'(k * GROUPS));
    end

    // Packed format: pick the highest boundary crossed as the device.
    always_comb begin
        pk_dev  = '0;
        pk_base = '0;
        for (int k = 1; k < NUM_DEV; k++) begin
            if (at_or_above[k]) begin
                pk_dev  = DEV_W'(k);
                pk_base = PAIR_W'(k * GROUPS);
            end
        end
        pk_off = 24'(pair - pk_base);
    end

    // Slot format: top bits select the device, the rest index 16-bit words.
    assign sl_dev  = addr[ADDR_W-1 -: DEV_W];
    assign sl_byte = 24'({addr[ADDR_W-DEV_W-1:0], 1'b0});

    // Final format select; packed offset times three as shift plus add.
    always_comb begin
        if (packed_fmt) begin
            dev_idx   = pk_dev;
            byte_addr = (pk_off << 1) + pk_off;
        end else begin
            dev_idx   = sl_dev;
            byte_addr = sl_byte;
        end
    end

    logic unused_w;
    assign unused_w = ^SLOT_W;
endmodule

// File: rtl/ssr_frame_build.sv
// Frame builder: lays out command, byte address and data bits MSB-aligned
// in a 56-bit vector and reports how many bits to send. Purely combinational.
module ssr_frame_build
    import ssr_pkg::*;
(
    input  logic              is_write,
    input  logic              packed_fmt,
    input  logic [23:0]       byte_addr,
    input  logic [SMP_W-1:0]  held_even,
    input  logic [SMP_W-1:0]  cur_sample,
    output logic [FRAME_W-1:0] frame,
    output logic [5:0]         nbits
);
    logic [7:0]  cmd;
    logic [23:0] payload;

    // Choose command byte and payload for the format and direction.
    always_comb begin
        cmd = is_write ? CMD_WRITE : CMD_READ;
        if (!is_write)
            payload = '0;
        else if (packed_fmt)
            payload = pack_pair(held_even, cur_sample);
        else
            payload = {slot_word(cur_sample), 8'h00};
        frame = {cmd, byte_addr, payload};
        nbits = packed_fmt ? BITS_PACK : BITS_SLOT;
    end
endmodule

// File: rtl/ssr_spi_shift.sv
// SPI mode 0 shifter: owns SCK, MOSI and the chip-selects for one frame.
// Assumes start is only raised while busy is low. last_fall marks the clock
// edge that ends the frame; rx holds the last 24 bits received.
module ssr_spi_shift
    import ssr_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int SCK_HALF = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [FRAME_W-1:0]         frame,
    input  logic [5:0]                 nbits,
    input  logic [$clog2(NUM_DEV)-1:0] dev_idx,
    input  logic                       miso,
    output logic                       sck,
    output logic                       mosi,
    output logic [NUM_DEV-1:0]         cs_n,
    output logic                       busy,
    output logic                       last_fall,
    output logic [RX_W-1:0]            rx
);
    localparam int DIV_W = $clog2(SCK_HALF + 1);

    logic [FRAME_W-1:0] tx_q;
    logic [5:0]         left_q;
    logic [DIV_W-1:0]   div_q;
    logic               sck_q;
    logic               busy_q;
    logic [NUM_DEV-1:0] cs_q;
    logic [NUM_DEV-1:0] cs_pick;
    logic [RX_W-1:0]    rx_q;
    logic               half_tick;

    // Decode the device index into an active-low select pattern.
    always_comb begin
        for (int i = 0; i < NUM_DEV; i++)
            cs_pick[i] = (dev_idx != i[$clog2(NUM_DEV)-1:0]);
    end

    assign half_tick = busy_q && (div_q == DIV_W'(SCK_HALF - 1));
    assign last_fall = half_tick && sck_q && (left_q == 6'd1);

    // Frame sequencer: half-period divider, SCK toggling, shift and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            cs_q   <= '1;
            tx_q   <= '0;
            left_q <= '0;
            div_q  <= '0;
            rx_q   <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            cs_q   <= cs_pick;
            tx_q   <= frame;
            left_q <= nbits;
            div_q  <= '0;
        end else if (busy_q) begin
            if (half_tick) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[RX_W-2:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (left_q == 6'd1) begin
                        busy_q <= 1'b0;
                        cs_q   <= '1;
                    end else begin
                        tx_q   <= tx_q << 1;
                        left_q <= left_q - 6'd1;
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign sck  = sck_q;
    assign mosi = tx_q[FRAME_W-1];
    assign cs_n = cs_q;
    assign busy = busy_q;
    assign rx   = rx_q;

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(tx_q[FRAME_W-1])); // R1
    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_q) <= 1); // R2
    AST_CS_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(cs_q)); // R2
endmodule

// File: rtl/ssr_sample_engine.sv
// Serial SRAM sample engine (top): accepts one sample read or write at a
// time, handles slot and packed formats, and drives the SPI bank through
// the shifter. Assumes requests are held until accepted (busy low).
module ssr_sample_engine
    import ssr_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int NUM_DEV   = 4,
    parameter int DEV_BYTES = 131072,
    parameter int SCK_HALF  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [11:0]        req_data,
    input  logic               pack_mode,
    output logic               busy,
    output logic               done,
    output logic [11:0]        rd_data,
    output logic               spi_sck,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic [NUM_DEV-1:0] spi_cs_n
);
    localparam int DEV_W = $clog2(NUM_DEV);

    logic                accept;
    logic                odd_addr;
    logic                need_frame;
    logic                start;
    logic [DEV_W-1:0]    dev_idx;
    logic [23:0]         byte_addr;
    logic [FRAME_W-1:0]  frame;
    logic [5:0]          nbits;
    logic                xfer_busy;
    logic                last_fall;
    logic [RX_W-1:0]     rx;
    logic [SMP_W-1:0]    even_hold;
    logic [SMP_W-1:0]    odd_hold;
    logic [SMP_W-1:0]    rd_q;
    logic                done_q;
    logic                rd_pend;
    logic                rd_pack;

    assign accept     = req_valid && !xfer_busy;
    assign odd_addr   = req_addr[0];
    assign need_frame = !pack_mode || (req_write ? odd_addr : !odd_addr);
    assign start      = accept && need_frame;

    ssr_addr_map #(
        .ADDR_W   (ADDR_W),
        .NUM_DEV  (NUM_DEV),
        .DEV_BYTES(DEV_BYTES)
    ) map_i (
        .addr      (req_addr),
        .packed_fmt(pack_mode),
        .dev_idx   (dev_idx),
        .byte_addr (byte_addr)
    );

    ssr_frame_build build_i (
        .is_write  (req_write),
        .packed_fmt(pack_mode),
        .byte_addr (byte_addr),
        .held_even (even_hold),
        .cur_sample(req_data),
        .frame     (frame),
        .nbits     (nbits)
    );

    ssr_spi_shift #(
        .NUM_DEV (NUM_DEV),
        .SCK_HALF(SCK_HALF)
    ) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .nbits    (nbits),
        .dev_idx  (dev_idx),
        .miso     (spi_miso),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n),
        .busy     (xfer_busy),
        .last_fall(last_fall),
        .rx       (rx)
    );

    // Request bookkeeping: sample holds, frame-less completions, read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_hold <= '0;
            odd_hold  <= '0;
            rd_q      <= '0;
            done_q    <= 1'b0;
            rd_pend   <= 1'b0;
            rd_pack   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept && pack_mode && req_write && !odd_addr) begin
                even_hold <= req_data;
                done_q    <= 1'b1;
            end
            if (accept && pack_mode && !req_write && odd_addr) begin
                rd_q   <= odd_hold;
                done_q <= 1'b1;
            end
            if (start) begin
                rd_pend <= !req_write;
                rd_pack <= pack_mode;
            end
            if (last_fall) begin
                done_q <= 1'b1;
                if (rd_pend) begin
                    if (rd_pack) begin
                        rd_q     <= rx[23:12];
                        odd_hold <= rx[11:0];
                    end else begin
                        rd_q <= rx[11:0];
                    end
                end
            end
        end
    end

    assign busy    = xfer_busy;
    assign done    = done_q;
    assign rd_data = rd_q;

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> !spi_sck); // R2
    AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&spi_cs_n) |-> done); // R11
    AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(&spi_cs_n) |-> busy); // R11
    AST_NO_SELECT_IN_RESET: assert property (@(posedge clk)
        (!rst_n && !$isunknown(spi_cs_n)) |=> (rst_n || (&spi_cs_n && !done && !busy))); // R12
endmodule

// File: tb/ssr_sample_engine_tb.sv
// Bench: behavioural SPI SRAM model, per-clock timing predictor and
// directed request sequences for both storage formats.
module ssr_sample_engine_tb_top;
    localparam int ADDR_W    = 18;
    localparam int NUM_DEV   = 4;
    localparam int DEV_BYTES = 131072;
    localparam int SCK_HALF  = 2;
    localparam int GROUPS    = DEV_BYTES / 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [11:0]        req_data = '0;
    logic               pack_mode = 1'b0;
    logic               busy;
    logic               done;
    logic [11:0]        rd_data;
    logic               spi_sck;
    logic               spi_mosi;
    logic               spi_miso = 1'b0;
    logic [NUM_DEV-1:0] spi_cs_n;

    int vec = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ssr_sample_engine #(
        .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .DEV_BYTES(DEV_BYTES), .SCK_HALF(SCK_HALF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_data(req_data), .pack_mode(pack_mode),
        .busy(busy), .done(done), .rd_data(rd_data), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural serial SRAM bank ----------------
    logic [7:0]  mem [int];
    int          bitcnt = 0;
    logic [31:0] hdr = '0;
    logic [7:0]  wbyte = '0;
    int          cur_dev = 0;
    int          frames = 0;
    int          last_bits = 0;
    int          last_dev = 0;
    logic [31:0] last_hdr = '0;
    logic        prev_sck = 1'b0;

    function automatic int key(input int d, input int a);
        return d * 32'h0100_0000 + a;
    endfunction

    function automatic logic [7:0] rd_mem(input int d, input int a);
        if (mem.exists(key(d, a))) return mem[key(d, a)];
        return 8'h00;
    endfunction

    function automatic int low_cs();
        for (int i = 0; i < NUM_DEV; i++) if (!spi_cs_n[i]) return i;
        return -1;
    endfunction

    // Device model: decode SCK edges seen at the clock, store and return bytes.
    always @(posedge clk) begin
        int s;
        int k;
        logic [7:0] b;
        s = low_cs();
        if (s >= 0) begin
            cur_dev = s;
            if (spi_sck && !prev_sck) begin
                if (bitcnt < 32) hdr = {hdr[30:0], spi_mosi};
                else begin
                    wbyte = {wbyte[6:0], spi_mosi};
                    k = bitcnt - 32;
                    if (hdr[31:24] == 8'h02 && (k % 8) == 7)
                        mem[key(s, int'(hdr[23:0]) + k / 8)] = wbyte;
                end
                bitcnt++;
            end
            if (!spi_sck && prev_sck && bitcnt >= 32 && hdr[31:24] == 8'h03) begin
                k = bitcnt - 32;
                b = rd_mem(s, int'(hdr[23:0]) + k / 8);
                spi_miso <= b[7 - (k % 8)];
            end
        end else if (bitcnt != 0) begin
            last_bits = bitcnt;
            last_hdr  = hdr;
            last_dev  = cur_dev;
            frames++;
            bitcnt = 0;
        end
        prev_sck = spi_sck;
    end

    // ---------------- per-clock timing reference ----------------
    int ncyc = 0;
    int exp_done_at = -1;
    int busy_from = 0;
    int busy_until = -1;

    always @(negedge clk) begin
        int nb;
        if (rst_n) begin
            ncyc++;
            chk("R11 done timing", 32'(done), 32'(ncyc == exp_done_at));
            chk("R11 busy window", 32'(busy), 32'(ncyc >= busy_from && ncyc <= busy_until));
            chk("R2 at most one select", 32'($countones(~spi_cs_n) <= 1), 32'd1);
            if (&spi_cs_n) chk("R2 idle sck low", 32'(spi_sck), 32'd0);
            if (req_valid && !busy) begin
                if (!pack_mode || (req_write ? req_addr[0] : !req_addr[0])) begin
                    nb = pack_mode ? 56 : 48;
                    busy_from   = ncyc + 1;
                    busy_until  = ncyc + 2 * nb * SCK_HALF;
                    exp_done_at = ncyc + 1 + 2 * nb * SCK_HALF;
                end else begin
                    exp_done_at = ncyc + 1;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_req(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [11:0] d, input logic pk);
        @(negedge clk);
        while (busy) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_data = d; pack_mode = pk;
        @(posedge clk); #1;
        req_valid = 1'b0;
        do @(negedge clk); while (!done);
        @(posedge clk); #1;
    endtask

    task automatic chk_frame(input string tag, input logic [7:0] cmd, input int dev,
                             input int ba, input int bits);
        chk({tag, " cmd+addr"}, last_hdr, {cmd, 24'(ba)});
        chk({tag, " device"}, 32'(last_dev), 32'(dev));
        chk({tag, " bit count"}, 32'(last_bits), 32'(bits));
    endtask

    logic [11:0] held_odd_exp;
    int f0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 cs high in reset", 32'(spi_cs_n), 32'(4'hF));
        chk("R12 sck low in reset", 32'(spi_sck), 32'd0);
        chk("R12 busy low in reset", 32'(busy), 32'd0);
        chk("R12 done low in reset", 32'(done), 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R3 R4 R1: slot write at low address
        do_req(1'b1, 18'h00005, 12'hABC, 1'b0);
        chk_frame("R1 R4 slot write", 8'h02, 0, 'h0A, 48);
        chk("R3 upper byte", 32'(rd_mem(0, 'h0A)), 32'h0A);
        chk("R3 lower byte", 32'(rd_mem(0, 'h0B)), 32'hBC);

        // R4: top address lands on the last device, last word
        do_req(1'b1, 18'h3FFFF, 12'h123, 1'b0);
        chk_frame("R4 slot top", 8'h02, 3, 'h1FFFE, 48);
        chk("R3 top upper byte", 32'(rd_mem(3, 'h1FFFE)), 32'h01);
        chk("R3 top lower byte", 32'(rd_mem(3, 'h1FFFF)), 32'h23);

        // R5: slot reads, including an upper nibble that must be ignored
        do_req(1'b0, 18'h00005, 12'h000, 1'b0);
        chk_frame("R1 R5 slot read", 8'h03, 0, 'h0A, 48);
        chk("R5 read data", 32'(rd_data), 32'hABC);
        mem[key(1, 'h200)] = 8'hF7;
        mem[key(1, 'h201)] = 8'h55;
        do_req(1'b0, 18'h10100, 12'h000, 1'b0);
        chk_frame("R4 R5 slot read dev1", 8'h03, 1, 'h200, 48);
        chk("R5 upper nibble ignored", 32'(rd_data), 32'h755);

        // R6 R7 R8: packed pair write
        f0 = frames;
        do_req(1'b1, 18'h00010, 12'h321, 1'b1);
        chk("R6 even write sends no frame", 32'(frames), 32'(f0));
        do_req(1'b1, 18'h00011, 12'h654, 1'b1);
        chk_frame("R7 R8 packed write", 8'h02, 0, 24, 56);
        chk("R7 byte0", 32'(rd_mem(0, 24)), 32'h32);
        chk("R7 byte1", 32'(rd_mem(0, 25)), 32'h16);
        chk("R7 byte2", 32'(rd_mem(0, 26)), 32'h54);

        // R9 R10: packed pair read
        do_req(1'b0, 18'h00010, 12'h000, 1'b1);
        chk_frame("R9 packed read", 8'h03, 0, 24, 56);
        chk("R9 even sample", 32'(rd_data), 32'h321);
        f0 = frames;
        do_req(1'b0, 18'h00011, 12'h000, 1'b1);
        chk("R10 odd read sends no frame", 32'(frames), 32'(f0));
        chk("R10 held odd sample", 32'(rd_data), 32'h654);

        // R8: device boundaries in packed format
        do_req(1'b1, 18'(2 * GROUPS), 12'h111, 1'b1);
        do_req(1'b1, 18'(2 * GROUPS + 1), 12'h222, 1'b1);
        chk_frame("R8 first pair of dev1", 8'h02, 1, 0, 56);
        chk("R8 dev1 bytes", {8'h0, rd_mem(1, 0), rd_mem(1, 1), rd_mem(1, 2)}, 32'h111222);
        do_req(1'b1, 18'(2 * (GROUPS - 1)), 12'hA0B, 1'b1);
        do_req(1'b1, 18'(2 * (GROUPS - 1) + 1), 12'hC0D, 1'b1);
        chk_frame("R8 last pair of dev0", 8'h02, 0, 3 * (GROUPS - 1), 56);
        chk("R8 dev0 tail bytes", {8'h0, rd_mem(0, 3 * (GROUPS - 1)), rd_mem(0, 3 * (GROUPS - 1) + 1),
            rd_mem(0, 3 * (GROUPS - 1) + 2)}, 32'hA0BC0D);
        do_req(1'b1, 18'h3FFFE, 12'hFED, 1'b1);
        do_req(1'b1, 18'h3FFFF, 12'h0C1, 1'b1);
        chk_frame("R8 last pair index", 8'h02, 3, 3 * (131071 - 3 * GROUPS), 56);
        do_req(1'b0, 18'(2 * GROUPS), 12'h000, 1'b1);
        chk("R9 boundary even", 32'(rd_data), 32'h111);
        held_odd_exp = 12'h222;
        do_req(1'b0, 18'(2 * GROUPS + 1), 12'h000, 1'b1);
        chk("R10 boundary odd", 32'(rd_data), 32'(held_odd_exp));

        // R11: request held through a busy frame is ignored
        f0 = frames;
        @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00005; pack_mode = 1'b0;
        @(posedge clk); #1;
        req_write = 1'b1; req_addr = 18'h00100; req_data = 12'hFFF;
        repeat (20) @(posedge clk);
        #1 req_valid = 1'b0;
        do @(negedge clk); while (!done);
        @(posedge clk); #1;
        chk("R11 read during ignore", 32'(rd_data), 32'hABC);
        chk("R11 one frame only", 32'(frames), 32'(f0 + 1));
        chk("R11 target untouched", 32'(rd_mem(0, 'h201)), 32'h00);

        repeat (5) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vec++;
        bad++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule